// File: doc/BRIEF.md
# FIFO Status and Interrupt Controller

This block pairs a transmit FIFO and a receive FIFO of the same depth for a serial controller. The bus side pushes words into the transmit FIFO and pops words from the receive FIFO. The serial engine pops from the transmit FIFO and pushes the words it receives into the receive FIFO. The block reports each FIFO's fill level and a 5-bit status word. It also raises a 5-bit interrupt vector. Two of its bits follow the levels against programmable thresholds. The other three are sticky error flags, cleared through a clear strobe.

The threshold registers keep only values below the FIFO depth. Software can therefore find the depth by writing growing values and reading each one back. A global enable gates the whole block. While it is low, both FIFOs are held empty and every sticky flag is held clear.

Top module: `fsic_top`

## Requirements
- R1: Each level output equals the accepted pushes minus the accepted pops, and stays between 0 and DEPTH. Words leave each FIFO in the order they entered. Each read-data output shows the head word, or zero while its FIFO is empty.
- R2: The status word has these bits: bit 0 is busy, which is set while enabled and either `eng_active` is high or the transmit FIFO is not empty. Bit 1 is transmit full, bit 2 transmit empty, bit 3 receive empty and bit 4 receive full.
- R3: A threshold write is retained only if the value is below DEPTH. A write of DEPTH or more leaves the previous value in place. Both thresholds reset to 0.
- R4: Interrupt bit 0 (transmit low) is high while the block is enabled and the transmit level is at or below the transmit threshold. It is not sticky.
- R5: Interrupt bit 4 (receive high) is high while the receive level is above the receive threshold. It is not sticky.
- R6: A bus push into a full transmit FIFO is dropped, and it sets sticky interrupt bit 1 (transmit overflow).
- R7: A bus pop from an empty receive FIFO returns zero and sets sticky interrupt bit 2 (receive underflow). An engine pop from an empty transmit FIFO has no effect and sets no flag.
- R8: An engine push into a full receive FIFO is dropped, and it sets sticky interrupt bit 3 (receive overflow).
- R9: A clear strobe acts on the bits of `clr_bits`. Bit 0 clears all three sticky flags. Bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq_masked` equals `irq_raw` ANDed with `irq_mask`, and `irq` is the OR of the bits of `irq_masked`.
- R11: When `en` is low, both FIFOs are emptied and all sticky flags are cleared at the next clock edge. Pushes made while `en` is low are ignored.
- R12: After reset, both levels are 0, the status word is 0x0C, `irq_raw` is 0 and both thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global enable; low flushes the FIFOs and the sticky flags |
| eng_active | input | 1 | Serial engine is shifting a word |
| bus_push | input | 1 | Bus push into the transmit FIFO |
| bus_wdata | input | DW | Word pushed by the bus |
| eng_pop | input | 1 | Engine pop from the transmit FIFO |
| eng_rdata | output | DW | Head of the transmit FIFO, 0 when empty |
| eng_push | input | 1 | Engine push into the receive FIFO |
| eng_wdata | input | DW | Word pushed by the engine |
| bus_pop | input | 1 | Bus pop from the receive FIFO |
| bus_rdata | output | DW | Head of the receive FIFO, 0 when empty |
| tx_thr_we | input | 1 | Transmit threshold write strobe |
| rx_thr_we | input | 1 | Receive threshold write strobe |
| thr_wdata | input | TW | Value written to a threshold |
| tx_thr | output | TW | Retained transmit threshold |
| rx_thr | output | TW | Retained receive threshold |
| irq_mask | input | 5 | Interrupt mask |
| clr_we | input | 1 | Clear strobe |
| clr_bits | input | 4 | Clear selection bits |
| tx_level | output | LW | Transmit FIFO entry count |
| rx_level | output | LW | Receive FIFO entry count |
| status | output | 5 | Status word |
| irq_raw | output | 5 | Unmasked interrupt vector |
| irq_masked | output | 5 | Masked interrupt vector |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with DEPTH=4, DW=8 and TW=4. A depth of 4 lets a single short vector walk reach both full FIFOs, every overflow and underflow flag, and both threshold crossings. A 4-bit threshold can be written with values from 4 up to 15, so the depth-discovery rejection is exercised with values just past the depth and far past it. With a transmit threshold of 1 and a receive threshold of 2, each level-based interrupt switches on and off in the middle of the walk rather than only at the empty or full edges.

// File: rtl/fsic_pkg.sv
package fsic_pkg;
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;

  localparam int IRQ_TXLOW  = 0;
  localparam int IRQ_TXOVF  = 1;
  localparam int IRQ_RXUND  = 2;
  localparam int IRQ_RXOVF  = 3;
  localparam int IRQ_RXHIGH = 4;

  localparam int CLR_ALL    = 0;
  localparam int CLR_RXUND  = 1;
  localparam int CLR_RXOVF  = 2;
  localparam int CLR_TXOVF  = 3;

  // threshold acceptance: only values below the depth are kept
  function automatic logic thr_fits(input logic [31:0] v, input int unsigned depth);
    return v < depth;
  endfunction

  // level at or below threshold
  function automatic logic at_or_below(input logic [31:0] lvl, input logic [31:0] thr);
    return lvl <= thr;
  endfunction

  // translate clear-register bits into a 5-bit interrupt-position vector
  function automatic logic [4:0] clr_to_irq(input logic [3:0] c);
    logic [4:0] r;
    r = '0;
    if (c[CLR_ALL]) begin
      r[IRQ_TXOVF] = 1'b1;
      r[IRQ_RXUND] = 1'b1;
      r[IRQ_RXOVF] = 1'b1;
    end
    if (c[CLR_RXUND]) r[IRQ_RXUND] = 1'b1;
    if (c[CLR_RXOVF]) r[IRQ_RXOVF] = 1'b1;
    if (c[CLR_TXOVF]) r[IRQ_TXOVF] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/fsic_fifo.sv
module fsic_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign push_drop = push & full & ~flush;
  assign pop_miss  = pop & empty & ~flush;
  assign rdata     = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  // R6 R8
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(level));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
endmodule

// File: rtl/fsic_thr.sv
module fsic_thr #(
  parameter int TW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] q
);
  import fsic_pkg::*;

  logic accept;
  assign accept = we & thr_fits(32'(wdata), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (accept) q <= wdata;
  end

  // R3
  keep_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !accept) |=> $stable(q));

  // R3
  thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(q) < DEPTH);
endmodule

// File: rtl/fsic_err.sv
module fsic_err #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (flush) q <= '0;
    else            q <= (q & ~clr) | set;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (set != '0)) |=> ((q & $past(set)) == $past(set)));

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q == '0));
endmodule

// File: rtl/fsic_top.sv
module fsic_top #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int TW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          eng_active,
  input  logic          bus_push,
  input  logic [DW-1:0] bus_wdata,
  input  logic          eng_pop,
  output logic [DW-1:0] eng_rdata,
  input  logic          eng_push,
  input  logic [DW-1:0] eng_wdata,
  input  logic          bus_pop,
  output logic [DW-1:0] bus_rdata,
  input  logic          tx_thr_we,
  input  logic          rx_thr_we,
  input  logic [TW-1:0] thr_wdata,
  output logic [TW-1:0] tx_thr,
  output logic [TW-1:0] rx_thr,
  input  logic [4:0]    irq_mask,
  input  logic          clr_we,
  input  logic [3:0]    clr_bits,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic [4:0]    status,
  output logic [4:0]    irq_raw,
  output logic [4:0]    irq_masked,
  output logic          irq
);
  import fsic_pkg::*;

  logic flush;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push_drop, tx_pop_miss, rx_push_drop, rx_pop_miss;
  logic [2:0] err_set, err_clr, err_q;
  logic [4:0] clr_vec;
  logic tx_low, rx_high;

  assign flush = ~en;

  fsic_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(bus_push), .wdata(bus_wdata), .pop(eng_pop), .rdata(eng_rdata),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_push_drop), .pop_miss(tx_pop_miss)
  );

  fsic_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(eng_push), .wdata(eng_wdata), .pop(bus_pop), .rdata(bus_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_push_drop), .pop_miss(rx_pop_miss)
  );

  fsic_thr #(.TW(TW), .DEPTH(DEPTH)) u_txthr (
    .clk(clk), .rst_n(rst_n), .we(tx_thr_we), .wdata(thr_wdata), .q(tx_thr)
  );

  fsic_thr #(.TW(TW), .DEPTH(DEPTH)) u_rxthr (
    .clk(clk), .rst_n(rst_n), .we(rx_thr_we), .wdata(thr_wdata), .q(rx_thr)
  );

  // sticky error order: [0] tx overflow, [1] rx underflow, [2] rx overflow
  assign clr_vec = clr_we ? clr_to_irq(clr_bits) : 5'b0;
  assign err_set = {rx_push_drop, rx_pop_miss, tx_push_drop};
  assign err_clr = clr_vec[IRQ_RXOVF:IRQ_TXOVF];

  fsic_err #(.N(3)) u_err (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .set(err_set), .clr(err_clr), .q(err_q)
  );

  assign tx_low  = en & at_or_below(32'(tx_level), 32'(tx_thr));
  assign rx_high = ~at_or_below(32'(rx_level), 32'(rx_thr));

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = en & (eng_active | ~tx_empty);
    status[ST_TXFULL]  = tx_full;
    status[ST_TXEMPTY] = tx_empty;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_RXFULL]  = rx_full;
  end

  always_comb begin
    irq_raw             = '0;
    irq_raw[IRQ_TXLOW]  = tx_low;
    irq_raw[IRQ_TXOVF]  = err_q[0];
    irq_raw[IRQ_RXUND]  = err_q[1];
    irq_raw[IRQ_RXOVF]  = err_q[2];
    irq_raw[IRQ_RXHIGH] = rx_high;
  end

  assign irq_masked = irq_raw & irq_mask;
  assign irq        = |irq_masked;

  // R7: an empty transmit pop is never recorded as an error
  tx_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_miss && !bus_pop && !eng_push && !bus_push && !clr_we && en
      && irq_raw[3:1] == 3'b000) |=> (irq_raw[3:1] == 3'b000));

  // R11
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_level == '0 && rx_level == '0 && irq_raw[3:1] == 3'b000));
endmodule

// File: tb/tb_fsic_top.sv
module tb_fsic_top;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int TW    = 4;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NV    = 22;
  localparam int VW    = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, eng_active = 1'b0;
  logic bus_push = 1'b0, eng_pop = 1'b0, eng_push = 1'b0, bus_pop = 1'b0;
  logic [DW-1:0] bus_wdata = '0, eng_wdata = '0, eng_rdata, bus_rdata;
  logic tx_thr_we = 1'b0, rx_thr_we = 1'b0;
  logic [TW-1:0] thr_wdata = '0, tx_thr, rx_thr;
  logic [4:0] irq_mask = 5'h1F;
  logic clr_we = 1'b0;
  logic [3:0] clr_bits = '0;
  logic [LW-1:0] tx_level, rx_level;
  logic [4:0] status, irq_raw, irq_masked;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fsic_top #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .eng_active(eng_active),
    .bus_push(bus_push), .bus_wdata(bus_wdata), .eng_pop(eng_pop), .eng_rdata(eng_rdata),
    .eng_push(eng_push), .eng_wdata(eng_wdata), .bus_pop(bus_pop), .bus_rdata(bus_rdata),
    .tx_thr_we(tx_thr_we), .rx_thr_we(rx_thr_we), .thr_wdata(thr_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .irq_mask(irq_mask),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .tx_level(tx_level), .rx_level(rx_level), .status(status),
    .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
  );

  // fields: bpush, bdata, epop, epush, edata, bpop, clr, exp txl, exp rxl, exp irq_raw
  // tx threshold 1, rx threshold 2, mask all ones
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,8'hA1,1'b0,1'b0,8'h00,1'b0,4'h0,3'd1,3'd0,5'h01}, // R4 low
    {1'b1,8'hA2,1'b0,1'b0,8'h00,1'b0,4'h0,3'd2,3'd0,5'h00}, // R4 above
    {1'b1,8'hA3,1'b0,1'b0,8'h00,1'b0,4'h0,3'd3,3'd0,5'h00},
    {1'b1,8'hA4,1'b0,1'b0,8'h00,1'b0,4'h0,3'd4,3'd0,5'h00},
    {1'b1,8'hA5,1'b0,1'b0,8'h00,1'b0,4'h0,3'd4,3'd0,5'h02}, // R6
    {1'b0,8'h00,1'b1,1'b0,8'h00,1'b0,4'h0,3'd3,3'd0,5'h02},
    {1'b0,8'h00,1'b0,1'b1,8'h11,1'b0,4'h0,3'd3,3'd1,5'h02},
    {1'b0,8'h00,1'b1,1'b1,8'h12,1'b0,4'h0,3'd2,3'd2,5'h02},
    {1'b0,8'h00,1'b1,1'b1,8'h13,1'b0,4'h0,3'd1,3'd3,5'h13}, // R5
    {1'b0,8'h00,1'b0,1'b1,8'h14,1'b0,4'h0,3'd1,3'd4,5'h13},
    {1'b0,8'h00,1'b0,1'b1,8'h15,1'b0,4'h0,3'd1,3'd4,5'h1B}, // R8
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b0,4'h8,3'd1,3'd4,5'h19}, // R9 tx ovf clear
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,4'h0,3'd1,3'd3,5'h19},
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,4'h0,3'd1,3'd2,5'h09}, // R5 off
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,4'h0,3'd1,3'd1,5'h09},
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,4'h0,3'd1,3'd0,5'h09},
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,4'h0,3'd1,3'd0,5'h0D}, // R7
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,4'h2,3'd1,3'd0,5'h0D}, // R9 set wins
    {1'b0,8'h00,1'b0,1'b0,8'h00,1'b0,4'h1,3'd1,3'd0,5'h01}, // R9 all clear
    {1'b0,8'h00,1'b1,1'b0,8'h00,1'b0,4'h0,3'd0,3'd0,5'h01},
    {1'b0,8'h00,1'b1,1'b0,8'h00,1'b0,4'h0,3'd0,3'd0,5'h01}, // R7 tx empty pop
    {1'b1,8'hB1,1'b1,1'b0,8'h00,1'b0,4'h0,3'd1,3'd0,5'h01}  // R1 push+pop empty
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic bp, input logic [7:0] bd, input logic ep,
                      input logic eps, input logic [7:0] ed, input logic bpp,
                      input logic [3:0] cl);
    bus_push = bp; bus_wdata = bd; eng_pop = ep; eng_push = eps; eng_wdata = ed;
    bus_pop = bpp; clr_we = (cl != 4'h0); clr_bits = cl;
    @(posedge clk); #5;
    bus_push = 1'b0; eng_pop = 1'b0; eng_push = 1'b0; bus_pop = 1'b0;
    clr_we = 1'b0; clr_bits = '0;
  endtask

  task automatic wthr(input logic is_rx, input logic [TW-1:0] v);
    thr_wdata = v; tx_thr_we = ~is_rx; rx_thr_we = is_rx;
    @(posedge clk); #5;
    tx_thr_we = 1'b0; rx_thr_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R12 reset state
    chk("R12 tx_level", 32'(tx_level), 0);
    chk("R12 rx_level", 32'(rx_level), 0);
    chk("R12 status", 32'(status), 32'h0C);
    chk("R12 irq_raw", 32'(irq_raw), 0);
    chk("R12 tx_thr", 32'(tx_thr), 0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    en = 1'b1;
    @(posedge clk); #5;

    // R3 threshold retention and depth discovery
    wthr(1'b0, 4'd3);  chk("R3 thr 3 kept", 32'(tx_thr), 3);
    wthr(1'b0, 4'd4);  chk("R3 thr 4 rejected", 32'(tx_thr), 3);
    wthr(1'b0, 4'd15); chk("R3 thr 15 rejected", 32'(tx_thr), 3);
    wthr(1'b0, 4'd1);  chk("R3 thr 1 kept", 32'(tx_thr), 1);
    wthr(1'b1, 4'd2);  chk("R3 rx thr 2 kept", 32'(rx_thr), 2);
    chk("R4 low at start", 32'(irq_raw), 32'h01);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[34], v[33:26], v[25], v[24], v[23:16], v[15], v[14:11]);
      chk($sformatf("R1 v%0d tx_level", i), 32'(tx_level), 32'(v[10:8]));
      chk($sformatf("R1 v%0d rx_level", i), 32'(rx_level), 32'(v[7:5]));
      chk($sformatf("R4-R9 v%0d irq_raw", i), 32'(irq_raw), 32'(v[4:0]));
    end

    // R1 ordering and empty read value
    chk("R1 rx empty rdata", 32'(bus_rdata), 0);
    chk("R1 tx head", 32'(eng_rdata), 32'hB1);
    step(1'b1, 8'hB2, 1'b0, 1'b0, 8'h00, 1'b0, 4'h0);
    step(1'b1, 8'hB3, 1'b0, 1'b0, 8'h00, 1'b0, 4'h0);
    // R2 busy with data queued
    chk("R2 busy tx data", 32'(status), 32'h09);
    step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'h0);
    chk("R1 tx order 2", 32'(eng_rdata), 32'hB2);
    step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'h0);
    chk("R1 tx order 3", 32'(eng_rdata), 32'hB3);
    step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'h0);
    chk("R1 tx drained rdata", 32'(eng_rdata), 0);
    chk("R2 idle status", 32'(status), 32'h0C);
    eng_active = 1'b1; #1;
    chk("R2 busy engine", 32'(status), 32'h0D);
    eng_active = 1'b0;

    // R10 masking
    irq_mask = 5'h02; #1;
    chk("R10 masked off", 32'({irq_masked, irq}), 0);
    irq_mask = 5'h01; #1;
    chk("R10 masked on", 32'({irq_masked, irq}), 32'h03);
    irq_mask = 5'h1F;

    // receive fill, order, full status
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hC1, 1'b0, 4'h0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hC2, 1'b0, 4'h0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hC3, 1'b0, 4'h0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hC4, 1'b0, 4'h0);
    chk("R2 rx full status", 32'(status), 32'h14);
    chk("R1 rx head", 32'(bus_rdata), 32'hC1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'h0);
    chk("R1 rx order", 32'(bus_rdata), 32'hC2);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hC5, 1'b0, 4'h0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hC6, 1'b0, 4'h0);
    chk("R8 second overflow", 32'(irq_raw[3]), 1);

    // R11 disable flushes, pushes ignored while low
    en = 1'b0;
    step(1'b1, 8'hD1, 1'b0, 1'b1, 8'hD2, 1'b0, 4'h0);
    chk("R11 tx_level", 32'(tx_level), 0);
    chk("R11 rx_level", 32'(rx_level), 0);
    chk("R11 irq_raw", 32'(irq_raw), 0);
    chk("R11 status", 32'(status), 32'h0C);
    en = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'h0);
    chk("R11 stays empty", 32'({tx_level, rx_level}), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule